// File: doc/BRIEF.md
# Circular Sample Buffer Readout Sequencer

This block is the digital side of a multi-channel sample-and-hold front end. While it is idle, every channel stores one digitized sample per clock into a ring of cells. All channels share one write position. Each channel also has a discriminator line. A pulse on that line sets a sticky hit flag, and the flag stays set until the end of the next readout. While no readout is running, the output stream carries one record per clock. That record holds the number of hit flags that are set, and a trigger processor outside the block can use it as multiplicity information.

A trigger pulse freezes the ring and latches the configured window offset and length. The sequencer then walks through the hit channels in ascending index order. For each one it reads every cell of the window, from the oldest cell to the newest, and wraps around the end of the ring when the window crosses it. One closing record marks the end of the event. Writing then resumes at the frozen position and all hit flags are cleared.

Top module: `ring_window_reader`

## Requirements
- R1: While `rst_n` is low, the next clock edge drives `rec_vld_o` low and drives `rec_kind_o`, `rec_ch_o`, `rec_cell_o` and `rec_data_o` to zero. After reset, the first sample is stored in cell 0.
- R2: While idle, each clock stores the whole sample bus into the current cell and advances the write cell by one, wrapping from cell 511 to cell 0. The sample presented in the trigger cycle is not stored, and no sample is stored during a readout or its closing cycle.
- R3: On a trigger, the window's first cell is (P − offset) mod 512, where P is the cell the trigger cycle would have written. A length field value L selects L+1 consecutive cells, which are read in increasing order modulo 512.
- R4: Only channels whose hit flag is set are read. A flag is set by a hit pulse on any idle cycle since the last readout, including the trigger cycle itself. Channels are read in ascending index order, and every window cell of one channel is read before the next channel starts.
- R5: A sample record has kind 1 and carries the channel index, the cell index and the 12-bit sample that was stored for that channel in that cell.
- R6: While idle, every clock produces a record of kind 0. Its data field holds the number of hit flags that were set before that clock edge (0 to 64).
- R7: During a readout, trigger pulses, hit pulses and changes to the window offset or length have no effect on the records or on the later flag state.
- R8: After the last selected channel, exactly one record of kind 2 with zero channel, cell and data fields follows. If no channel was selected, this record is the only record of the event. After it, the hit flags are clear and the next record has kind 0.
- R9: After reset is released, `rec_vld_o` is high on every cycle, so the block emits exactly one record per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 768 | Sample bus, channel c in bits [12c+11:12c] |
| hit_i | input | 64 | Per-channel discriminator pulses |
| trig_i | input | 1 | Readout request |
| win_ofs_i | input | 9 | Window start offset behind the write cell |
| win_len_i | input | 9 | Window length minus one |
| rec_vld_o | output | 1 | Record valid |
| rec_kind_o | output | 2 | 0 multiplicity, 1 sample, 2 end of event |
| rec_ch_o | output | 6 | Channel index of a sample record |
| rec_cell_o | output | 9 | Cell index of a sample record |
| rec_data_o | output | 12 | Sample value or multiplicity count |

## Verification
The situation that is hardest to reach from the ports is a trigger that arrives while the write cell sits just past cell 0 and the offset is larger than that cell index. Only then does the window start near the top of the ring and wrap through cell 0 during the readout. The stimulus reaches it by filling the ring and then letting the bench's reference model follow the write position cycle by cycle. The trigger is pulsed on the exact cycle the model reports cell 3. Retriggers, new hit pulses and configuration changes are injected partway through a readout, so any leak into the records or into the multiplicity that follows is visible.

// File: rtl/rwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the ring window reader.
// Assumes: record kinds fit in two bits and the sequencer has two states.
package rwr_pkg;

    typedef enum logic [1:0] {
        REC_MULT   = 2'd0,
        REC_SAMPLE = 2'd1,
        REC_EOE    = 2'd2
    } rec_kind_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_READ = 1'b1
    } seq_state_t;

endpackage

// File: rtl/rwr_ring_store.sv
`timescale 1ns/1ps
// Ring sample store: one wide word per cell holds the samples of all channels.
// Writes the whole bus into the current cell whenever wr_en is high and then
// advances the cell index with a wrap at DEPTH-1.
// Assumes: the memory contents have no reset, and a cell is read only after
// it has been written once.
module rwr_ring_store #(
    parameter int NCH   = 64,
    parameter int DEPTH = 512,
    parameter int DW    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [NCH*DW-1:0]          wr_word,
    input  logic [$clog2(DEPTH)-1:0]   rd_cell,
    input  logic [$clog2(NCH)-1:0]     rd_ch,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [DW-1:0]              rd_data
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] LAST_CELL = CW'(DEPTH - 1);

    logic [NCH*DW-1:0] mem [DEPTH];
    logic [CW-1:0]     wr_ptr_q;
    logic [NCH*DW-1:0] rd_word;
    logic [DW-1:0]     lane [NCH];

    // Store the sample word in the current cell.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            mem[wr_ptr_q] <= wr_word;
        end
    end

    // Advance the write cell while writing, wrapping at the last cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= (wr_ptr_q == LAST_CELL) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    assign rd_word = mem[rd_cell];

    // Split the read word into one lane per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign lane[g] = rd_word[g*DW +: DW];
    end

    assign rd_data = lane[rd_ch];
    assign wr_ptr  = wr_ptr_q;

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_ptr_q));

    // R2
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr_q == LAST_CELL) |=> (wr_ptr_q == '0));

endmodule

// File: rtl/rwr_hit_track.sv
`timescale 1ns/1ps
// Hit tracker: keeps one sticky flag per channel and counts the flags that
// are set.
// Flags pick up discriminator pulses only while capture_en is high, and clear
// is stronger than capture.
// Assumes: the count width $clog2(NCH+1) holds the value NCH.
module rwr_hit_track #(
    parameter int NCH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           hit_i,
    input  logic                     capture_en,
    input  logic                     clear,
    output logic [NCH-1:0]           flags,
    output logic [$clog2(NCH+1)-1:0] mult
);
    localparam int MW = $clog2(NCH + 1);

    logic [NCH-1:0] flags_q;

    // Collect the hit pulses into sticky flags and clear them at event end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clear) begin
            flags_q <= '0;
        end else if (capture_en) begin
            flags_q <= flags_q | hit_i;
        end
    end

    // Count the flags that are set.
    always_comb begin
        mult = '0;
        for (int i = 0; i < NCH; i++) begin
            mult = mult + MW'(flags_q[i]);
        end
    end

    assign flags = flags_q;

    // R7
    flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !clear) |=> $stable(flags_q));

endmodule

// File: rtl/rwr_sequencer.sv
`timescale 1ns/1ps
// Readout sequencer: on a trigger it latches the selected channel mask, the
// window start and the window length. It then walks through the selected
// channels from the lowest index up and reads every window cell of each one
// before it moves on. When no channel is left, it raises eoe for one cycle
// and returns to idle.
// Assumes: the offset is below DEPTH, and the trigger is ignored outside idle.
module rwr_sequencer #(
    parameter int NCH   = 64,
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_i,
    input  logic [NCH-1:0]             flags_i,
    input  logic [NCH-1:0]             hit_i,
    input  logic [$clog2(DEPTH)-1:0]   wr_ptr_i,
    input  logic [$clog2(DEPTH)-1:0]   ofs_i,
    input  logic [$clog2(DEPTH)-1:0]   len_i,
    output logic                       busy,
    output logic                       eoe,
    output logic [$clog2(NCH)-1:0]     rd_ch,
    output logic [$clog2(DEPTH)-1:0]   rd_cell
);
    import rwr_pkg::*;

    localparam int CW  = $clog2(DEPTH);
    localparam int CHW = $clog2(NCH);
    localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

    seq_state_t     st_q;
    logic [NCH-1:0] rem_q;
    logic [CW-1:0]  start_q;
    logic [CW-1:0]  len_q;
    logic [CW-1:0]  k_q;
    logic [CW:0]    start_diff;
    logic [CW-1:0]  start_nxt;
    logic [CW:0]    cell_sum;
    logic [CHW-1:0] cur_ch;
    logic           any_left;

    // Compute the window start as the write cell minus the offset, modulo DEPTH.
    always_comb begin
        start_diff = {1'b0, wr_ptr_i} + DEPTH_W - {1'b0, ofs_i};
        if (start_diff >= DEPTH_W) begin
            start_diff = start_diff - DEPTH_W;
        end
        start_nxt = start_diff[CW-1:0];
    end

    // Select the lowest channel that is still waiting to be read.
    always_comb begin
        cur_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rem_q[i]) begin
                cur_ch = CHW'(i);
            end
        end
    end

    assign any_left = |rem_q;

    // Compute the current cell from the start and the step count, modulo DEPTH.
    always_comb begin
        cell_sum = {1'b0, start_q} + {1'b0, k_q};
        if (cell_sum >= DEPTH_W) begin
            cell_sum = cell_sum - DEPTH_W;
        end
        rd_cell = cell_sum[CW-1:0];
    end

    // Run the idle/read state machine, the channel mask and the cell step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            rem_q   <= '0;
            start_q <= '0;
            len_q   <= '0;
            k_q     <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (trig_i) begin
                        st_q    <= SEQ_READ;
                        rem_q   <= flags_i | hit_i;
                        start_q <= start_nxt;
                        len_q   <= len_i;
                        k_q     <= '0;
                    end
                end
                default: begin
                    if (!any_left) begin
                        st_q <= SEQ_IDLE;
                    end else if (k_q == len_q) begin
                        k_q           <= '0;
                        rem_q[cur_ch] <= 1'b0;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy  = (st_q == SEQ_READ);
    assign eoe   = busy && !any_left;
    assign rd_ch = cur_ch;

    // R7
    window_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(start_q) && $stable(len_q)));

    // R4
    mask_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (((rem_q & ~$past(rem_q)) == '0) &&
                  ($countones($past(rem_q)) - $countones(rem_q) <= 1)));

    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (k_q <= len_q));

endmodule

// File: rtl/ring_window_reader.sv
`timescale 1ns/1ps
// Ring window reader top: connects the ring store, the hit tracker and the
// readout sequencer, and drives one registered record per clock.
// While idle, the record carries the multiplicity. During a readout it
// carries samples, and at the end of the event a closing marker.
// Assumes: the multiplicity count width is not wider than DW, and DEPTH is a
// power of two.
module ring_window_reader #(
    parameter int NCH   = 64,
    parameter int DEPTH = 512,
    parameter int DW    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH*DW-1:0]          smp_i,
    input  logic [NCH-1:0]             hit_i,
    input  logic                       trig_i,
    input  logic [$clog2(DEPTH)-1:0]   win_ofs_i,
    input  logic [$clog2(DEPTH)-1:0]   win_len_i,
    output logic                       rec_vld_o,
    output logic [1:0]                 rec_kind_o,
    output logic [$clog2(NCH)-1:0]     rec_ch_o,
    output logic [$clog2(DEPTH)-1:0]   rec_cell_o,
    output logic [DW-1:0]              rec_data_o
);
    import rwr_pkg::*;

    localparam int CW  = $clog2(DEPTH);
    localparam int CHW = $clog2(NCH);
    localparam int MW  = $clog2(NCH + 1);
    localparam logic [DW-1:0] MAX_MULT = DW'(NCH);

    logic            busy;
    logic            eoe;
    logic            wr_en;
    logic [CW-1:0]   wr_ptr;
    logic [CW-1:0]   rd_cell;
    logic [CHW-1:0]  rd_ch;
    logic [DW-1:0]   rd_data;
    logic [NCH-1:0]  flags;
    logic [MW-1:0]   mult;

    assign wr_en = !busy && !trig_i;

    rwr_ring_store #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (smp_i),
        .rd_cell (rd_cell),
        .rd_ch   (rd_ch),
        .wr_ptr  (wr_ptr),
        .rd_data (rd_data)
    );

    rwr_hit_track #(.NCH(NCH)) u_hits (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_i),
        .capture_en (!busy),
        .clear      (eoe),
        .flags      (flags),
        .mult       (mult)
    );

    rwr_sequencer #(.NCH(NCH), .DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .flags_i  (flags),
        .hit_i    (hit_i),
        .wr_ptr_i (wr_ptr),
        .ofs_i    (win_ofs_i),
        .len_i    (win_len_i),
        .busy     (busy),
        .eoe      (eoe),
        .rd_ch    (rd_ch),
        .rd_cell  (rd_cell)
    );

    // Register the outgoing record: multiplicity, sample or end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld_o  <= 1'b0;
            rec_kind_o <= REC_MULT;
            rec_ch_o   <= '0;
            rec_cell_o <= '0;
            rec_data_o <= '0;
        end else begin
            rec_vld_o <= 1'b1;
            if (!busy) begin
                rec_kind_o <= REC_MULT;
                rec_ch_o   <= '0;
                rec_cell_o <= '0;
                rec_data_o <= DW'(mult);
            end else if (eoe) begin
                rec_kind_o <= REC_EOE;
                rec_ch_o   <= '0;
                rec_cell_o <= '0;
                rec_data_o <= '0;
            end else begin
                rec_kind_o <= REC_SAMPLE;
                rec_ch_o   <= rd_ch;
                rec_cell_o <= rd_cell;
                rec_data_o <= rd_data;
            end
        end
    end

    // R9
    always_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rec_vld_o);

    // R8
    eoe_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld_o && rec_kind_o == REC_EOE) |=>
        (rec_kind_o == REC_MULT && rec_data_o == '0));

    // R6
    mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld_o && rec_kind_o == REC_MULT) |-> (rec_data_o <= MAX_MULT));

endmodule

// File: tb/ring_window_reader_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model follows the block cycle by cycle, and
// every record is compared with the model on each falling edge.
module ring_window_reader_bench;
    localparam int NCH   = 64;
    localparam int DEPTH = 512;
    localparam int DW    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] smp_i = '0;
    logic [NCH-1:0]    hit_i = '0;
    logic              trig_i = 1'b0;
    logic [8:0]        win_ofs_i = '0;
    logic [8:0]        win_len_i = '0;
    logic              rec_vld_o;
    logic [1:0]        rec_kind_o;
    logic [5:0]        rec_ch_o;
    logic [8:0]        rec_cell_o;
    logic [11:0]       rec_data_o;

    ring_window_reader u_ring_window_reader (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .hit_i(hit_i), .trig_i(trig_i),
        .win_ofs_i(win_ofs_i), .win_len_i(win_len_i), .rec_vld_o(rec_vld_o),
        .rec_kind_o(rec_kind_o), .rec_ch_o(rec_ch_o), .rec_cell_o(rec_cell_o),
        .rec_data_o(rec_data_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 0;
    int cur_tag = 0;
    int tag_ctr = 0;

    // Reference model state.
    int m_st = 0;
    int m_wptr = 0;
    int cell_t[DEPTH];
    bit [NCH-1:0] m_flags = '0;
    int chq[$];
    int m_start = 0, m_len = 0, m_k = 0;
    int e_vld = 0, e_kind = 0, e_ch = 0, e_cell = 0, e_data = 0;

    function automatic int gen(int tag, int ch);
        return (tag * 37 + ch * 101 + 5) & 12'hFFF;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Drive a fresh sample pattern on every falling edge.
    always @(negedge clk) begin
        tag_ctr++;
        cur_tag = tag_ctr;
        for (int c = 0; c < NCH; c++) smp_i[c*DW +: DW] = 12'(gen(tag_ctr, c));
    end

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_vld = 0; e_kind = 0; e_ch = 0; e_cell = 0; e_data = 0;
            m_wptr = 0; m_flags = '0; m_st = 0; chq.delete(); m_k = 0;
        end else begin
            e_vld = 1;
            if (m_st == 0) begin
                e_kind = 0; e_ch = 0; e_cell = 0;
                e_data = $countones(m_flags);
                m_flags = m_flags | hit_i;
                if (trig_i) begin
                    chq.delete();
                    for (int c = 0; c < NCH; c++) if (m_flags[c]) chq.push_back(c);
                    m_start = (m_wptr - int'(win_ofs_i) + DEPTH) % DEPTH;
                    m_len = int'(win_len_i);
                    m_k = 0;
                    m_st = 1;
                end else begin
                    cell_t[m_wptr] = cur_tag;
                    m_wptr = (m_wptr + 1) % DEPTH;
                end
            end else begin
                if (chq.size() == 0) begin
                    e_kind = 2; e_ch = 0; e_cell = 0; e_data = 0;
                    m_flags = '0;
                    m_st = 0;
                end else begin
                    e_kind = 1;
                    e_ch = chq[0];
                    e_cell = (m_start + m_k) % DEPTH;
                    e_data = gen(cell_t[e_cell], e_ch);
                    if (m_k == m_len) begin
                        void'(chq.pop_front());
                        m_k = 0;
                    end else begin
                        m_k++;
                    end
                end
            end
        end
    end

    // Compare the record with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            if (e_vld == 0) begin
                check("R1 valid", int'(rec_vld_o), 0);
                check("R1 kind", int'(rec_kind_o), 0);
                check("R1 data", int'(rec_data_o), 0);
                check("R1 cell", int'(rec_cell_o), 0);
            end else begin
                check("R9 valid", int'(rec_vld_o), 1);
                if (e_kind == 0) begin
                    check("R6 kind", int'(rec_kind_o), 0);
                    check("R6 multiplicity", int'(rec_data_o), e_data);
                end else if (e_kind == 1) begin
                    check("R4 kind", int'(rec_kind_o), 1);
                    check("R4 channel", int'(rec_ch_o), e_ch);
                    check("R3 cell", int'(rec_cell_o), e_cell);
                    check("R5 data", int'(rec_data_o), e_data);
                end else begin
                    check("R8 kind", int'(rec_kind_o), 2);
                    check("R8 fields", int'(rec_data_o) + int'(rec_ch_o) + int'(rec_cell_o), 0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hit(bit [NCH-1:0] m);
        @(negedge clk); hit_i = m;
        @(negedge clk); hit_i = '0;
    endtask

    task automatic pulse_trig(int ofs, int len, bit [NCH-1:0] m);
        @(negedge clk);
        win_ofs_i = 9'(ofs); win_len_i = 9'(len); trig_i = 1'b1; hit_i = m;
        @(negedge clk);
        trig_i = 1'b0; hit_i = '0;
    endtask

    task automatic wait_idle();
        while (m_st != 0) @(negedge clk);
        idle(3);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) cell_t[i] = 0;
        // R1: reset state
        idle(2);
        cmp_on = 1;
        idle(3);
        rst_n = 1'b1;
        // R2/R6: fill the ring while the multiplicity changes
        idle(100);
        pulse_hit(64'h8);
        idle(100);
        pulse_hit((64'h1 << 10) | (64'h1 << 63));
        idle(100);
        pulse_hit(64'h8);
        idle(300);
        // R3/R4/R5: window readout, with a hit in the trigger cycle on ch20
        pulse_trig(5, 7, 64'h1 << 20);
        wait_idle();
        // R7: retrigger, hits and configuration changes during a readout
        pulse_hit(64'h6);
        idle(4);
        pulse_trig(100, 3, '0);
        idle(2);
        win_ofs_i = 9'd7; win_len_i = 9'd200; trig_i = 1'b1; hit_i = 64'h1 << 40;
        @(negedge clk);
        trig_i = 1'b0; hit_i = '0;
        wait_idle();
        idle(5);
        // R8: trigger with no channel hit
        pulse_trig(0, 10, '0);
        wait_idle();
        // R3: window wraps through cell 0
        pulse_hit(64'h1);
        while (m_wptr != 2) @(negedge clk);
        pulse_trig(10, 20, '0);
        wait_idle();
        // R3: full-ring window on the highest channel
        pulse_hit(64'h1 << 63);
        idle(20);
        pulse_trig(0, 511, '0);
        wait_idle();
        // R2: trigger exactly at the last cell
        pulse_hit(64'h1 << 5);
        while (m_wptr != 510) @(negedge clk);
        pulse_trig(0, 1, '0);
        wait_idle();
        idle(50);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule